// File: doc/BRIEF.md
# Double-Word Register Store Sequencer

This block carries out one conditional store of a 64-bit floating-point register through a 32-bit write port. A single-cycle start pulse hands it a decoded store command: a condition code, the current status flags, a direction bit, a base address and a word offset, together with the 64-bit source value and an endianness setting. When the condition holds, the block forms the effective address and sends the two 32-bit halves as two write beats, to consecutive word addresses. The endianness setting decides which half goes first.

Each beat uses a valid/ready handshake. A fault reported on an accepted beat ends the store with a data abort. A base address that is not word-aligned ends it with an alignment abort before any write. A condition that fails ends the store at once with no memory traffic. Every command finishes with a one-cycle done pulse, and the abort flags are valid in that same cycle.

The controller has four states. IDLE waits for start. FIRST presents the beat at the effective address. SECOND presents the beat at the effective address + 4. FINISH raises done. The transitions are:
- IDLE→FINISH on start when the condition fails.
- IDLE→FINISH on start when the condition passes and the base is misaligned.
- IDLE→FIRST on start when the condition passes and the base is aligned.
- FIRST→FIRST while the beat is not accepted.
- FIRST→FINISH when the beat is accepted with a fault.
- FIRST→SECOND when the beat is accepted cleanly.
- SECOND→SECOND while the beat is not accepted.
- SECOND→FINISH when the beat is accepted.
- FINISH→IDLE always.

Top module: `dws_store_seq`

## Requirements
- R1: A start pulse is accepted only in IDLE, and it captures every command field. A start raised while a store is in progress, including the done cycle, is ignored and changes neither the beats nor the result.
- R2: The effective address is base + offset×4 when up_i is 1 and base − offset×4 when up_i is 0, taken modulo 2^32. An offset of 0 stores at the base itself.
- R3: The condition uses flags_i = {N,Z,C,V} in bits 3..0. The codes are:

  | cond_i | Passes when |
  |---|---|
  | 0 | Z |
  | 1 | !Z |
  | 2 | C |
  | 3 | !C |
  | 4 | N |
  | 5 | !N |
  | 6 | V |
  | 7 | !V |
  | 8 | C&!Z |
  | 9 | !C\|Z |
  | 10 | N==V |
  | 11 | N!=V |
  | 12 | !Z&(N==V) |
  | 13 | Z\|(N!=V) |
  | 14 | always |
  | 15 | never |

- R4: When the condition fails, done_o is high in the cycle right after the start edge. No beat is issued, and abort_o and misalign_o stay low.
- R5: With big_endian_i=1, data bits 63:32 go to the effective address and bits 31:0 to the effective address + 4. With big_endian_i=0 the halves swap. The beat at the effective address is always issued first, and the second beat follows only after the first is accepted.
- R6: While mem_valid_o is high and mem_ready_i is low, mem_addr_o and mem_wdata_o hold their values.
- R7: A beat accepted with mem_fault_i high ends the store. In the next cycle done_o and abort_o are high and no further beat is issued.
- R8: When the condition passes and base bits 1:0 are not zero, done_o and misalign_o are high in the cycle after the start edge, and no beat is issued. A failing condition takes precedence, and in that case misalign_o stays low.
- R9: done_o is a single-cycle pulse. On a clean store it comes in the cycle after the second beat is accepted, with both abort flags low. Every beat address is word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle command strobe |
| cond_i | input | 4 | Condition code |
| flags_i | input | 4 | Status flags {N,Z,C,V} |
| up_i | input | 1 | 1: add offset, 0: subtract |
| base_i | input | 32 | Base byte address |
| offset_i | input | 8 | Offset in words |
| data_i | input | 64 | Register value to store |
| big_endian_i | input | 1 | Half order select |
| mem_valid_o | output | 1 | Write beat valid |
| mem_addr_o | output | 32 | Write beat byte address |
| mem_wdata_o | output | 32 | Write beat data |
| mem_ready_i | input | 1 | Beat accepted |
| mem_fault_i | input | 1 | Fault on the accepted beat |
| done_o | output | 1 | Command finished pulse |
| abort_o | output | 1 | Data abort, valid with done |
| misalign_o | output | 1 | Alignment abort, valid with done |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 64-bit register and an 8-bit offset. With these values the largest offset of 255 words is reachable in both directions, and bases near zero or near the top of the space drive the address arithmetic through its modulo-2^32 wrap. All sixteen condition codes are swept against two flag patterns. The memory model stalls, faults on either beat, and sees stray start pulses raised in the middle of a store.

// File: rtl/dws_pkg.sv
package dws_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_FINISH = 2'd3
    } dws_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } dws_flags_t;
endpackage

// File: rtl/dws_cond_eval.sv
module dws_cond_eval
    import dws_pkg::*;
(
    input  logic [3:0] cond,
    input  logic [3:0] flags,
    output logic       pass
);
    dws_flags_t f;

    always_comb begin
        f = dws_flags_t'(flags);
        unique case (cond)
            4'd0:  pass = f.z;
            4'd1:  pass = !f.z;
            4'd2:  pass = f.c;
            4'd3:  pass = !f.c;
            4'd4:  pass = f.n;
            4'd5:  pass = !f.n;
            4'd6:  pass = f.v;
            4'd7:  pass = !f.v;
            4'd8:  pass = f.c && !f.z;
            4'd9:  pass = !f.c || f.z;
            4'd10: pass = (f.n == f.v);
            4'd11: pass = (f.n != f.v);
            4'd12: pass = !f.z && (f.n == f.v);
            4'd13: pass = f.z || (f.n != f.v);
            4'd14: pass = 1'b1;
            4'd15: pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/dws_addr_gen.sv
module dws_addr_gen #(
    parameter int ADDR_W   = 32,
    parameter int OFF_W    = 8,
    parameter int SCALE_SH = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  logic              up,
    output logic [ADDR_W-1:0] ea_first,
    output logic [ADDR_W-1:0] ea_second,
    output logic              misaligned
);
    localparam int BEAT_BYTES = 1 << SCALE_SH;

    logic [ADDR_W-1:0] scaled;

    always_comb begin
        scaled    = ADDR_W'(offset) << SCALE_SH;
        ea_first  = up ? (base + scaled) : (base - scaled);
        ea_second = ea_first + ADDR_W'(BEAT_BYTES);
    end

    generate
        if (SCALE_SH == 0) begin : g_no_align
            assign misaligned = 1'b0;
        end else begin : g_align
            assign misaligned = |base[SCALE_SH-1:0];
        end
    endgenerate
endmodule

// File: rtl/dws_beat_sel.sv
module dws_beat_sel #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]   data,
    input  logic                big_endian,
    input  logic                second,
    output logic [DATA_W/2-1:0] beat
);
    localparam int HALF = DATA_W / 2;

    // Upper half leads in big-endian order, trails in little-endian order.
    always_comb begin
        if (big_endian ^ second)
            beat = data[DATA_W-1:HALF];
        else
            beat = data[HALF-1:0];
    end
endmodule

// File: rtl/dws_store_seq.sv
module dws_store_seq
    import dws_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int OFF_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [3:0]            cond_i,
    input  logic [3:0]            flags_i,
    input  logic                  up_i,
    input  logic [ADDR_W-1:0]     base_i,
    input  logic [OFF_W-1:0]      offset_i,
    input  logic [DATA_W-1:0]     data_i,
    input  logic                  big_endian_i,
    output logic                  mem_valid_o,
    output logic [ADDR_W-1:0]     mem_addr_o,
    output logic [DATA_W/2-1:0]   mem_wdata_o,
    input  logic                  mem_ready_i,
    input  logic                  mem_fault_i,
    output logic                  done_o,
    output logic                  abort_o,
    output logic                  misalign_o
);
    localparam int BEAT_W   = DATA_W / 2;
    localparam int SCALE_SH = $clog2(BEAT_W / 8);

    dws_state_e        state_q, state_d;
    logic              cond_pass, misaligned;
    logic [ADDR_W-1:0] ea_first, ea_second;
    logic [ADDR_W-1:0] ea1_q, ea2_q;
    logic [DATA_W-1:0] data_q;
    logic              be_q;
    logic              abort_q, misalign_q;
    logic [BEAT_W-1:0] beat;
    logic              accept;

    dws_cond_eval u_cond (
        .cond  (cond_i),
        .flags (flags_i),
        .pass  (cond_pass)
    );

    dws_addr_gen #(
        .ADDR_W   (ADDR_W),
        .OFF_W    (OFF_W),
        .SCALE_SH (SCALE_SH)
    ) u_addr (
        .base       (base_i),
        .offset     (offset_i),
        .up         (up_i),
        .ea_first   (ea_first),
        .ea_second  (ea_second),
        .misaligned (misaligned)
    );

    dws_beat_sel #(
        .DATA_W (DATA_W)
    ) u_beat (
        .data       (data_q),
        .big_endian (be_q),
        .second     (state_q == ST_SECOND),
        .beat       (beat)
    );

    assign accept = (state_q == ST_IDLE) && start_i;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (!cond_pass || misaligned)
                        state_d = ST_FINISH;
                    else
                        state_d = ST_FIRST;
                end
            end
            ST_FIRST: begin
                if (mem_ready_i)
                    state_d = mem_fault_i ? ST_FINISH : ST_SECOND;
            end
            ST_SECOND: begin
                if (mem_ready_i)
                    state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Command capture and result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea1_q      <= '0;
            ea2_q      <= '0;
            data_q     <= '0;
            be_q       <= 1'b0;
            abort_q    <= 1'b0;
            misalign_q <= 1'b0;
        end else if (accept) begin
            ea1_q      <= ea_first;
            ea2_q      <= ea_second;
            data_q     <= data_i;
            be_q       <= big_endian_i;
            abort_q    <= 1'b0;
            misalign_q <= cond_pass && misaligned;
        end else if (mem_valid_o && mem_ready_i && mem_fault_i) begin
            abort_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        mem_valid_o = 1'b0;
        mem_addr_o  = ea1_q;
        mem_wdata_o = beat;
        done_o      = 1'b0;
        abort_o     = 1'b0;
        misalign_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_FIRST:  mem_valid_o = 1'b1;
            ST_SECOND: begin
                mem_valid_o = 1'b1;
                mem_addr_o  = ea2_q;
            end
            ST_FINISH: begin
                done_o     = 1'b1;
                abort_o    = abort_q;
                misalign_o = misalign_q;
            end
        endcase
    end
endmodule

// File: rtl/dws_store_seq_chk.sv
module dws_store_seq_chk #(
    parameter int ADDR_W     = 32,
    parameter int BEAT_W     = 32,
    parameter int BEAT_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_valid_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [BEAT_W-1:0] mem_wdata_o,
    input logic              mem_ready_i,
    input logic              mem_fault_i,
    input logic              done_o,
    input logic              abort_o,
    input logic              misalign_o
);
    a_r6_hold_until_accept: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_wdata_o));

    a_r7_fault_ends_store: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o && mem_ready_i && mem_fault_i |=> !mem_valid_o && done_o && abort_o);

    a_r5_next_beat_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o && mem_ready_i |=> !mem_valid_o || (mem_addr_o == $past(mem_addr_o) + ADDR_W'(BEAT_BYTES)));

    a_r8_misalign_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |-> done_o && !mem_valid_o);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_beat_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o |-> (mem_addr_o % BEAT_BYTES) == 0);

    a_r7_abort_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> done_o && !mem_valid_o);
endmodule

bind dws_store_seq dws_store_seq_chk #(
    .ADDR_W     (ADDR_W),
    .BEAT_W     (DATA_W / 2),
    .BEAT_BYTES (DATA_W / 16)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_valid_o (mem_valid_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ready_i (mem_ready_i),
    .mem_fault_i (mem_fault_i),
    .done_o      (done_o),
    .abort_o     (abort_o),
    .misalign_o  (misalign_o)
);

// File: tb/dws_store_seq_bench.sv
module dws_store_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  cond_i = '0;
    logic [3:0]  flags_i = '0;
    logic        up_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [7:0]  offset_i = '0;
    logic [63:0] data_i = '0;
    logic        big_endian_i = 1'b0;
    logic        mem_valid_o;
    logic [31:0] mem_addr_o;
    logic [31:0] mem_wdata_o;
    logic        mem_ready_i = 1'b0;
    logic        mem_fault_i = 1'b0;
    logic        done_o, abort_o, misalign_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int start_cyc = 0;
    int done_cnt = 0;
    int stall_n = 0;
    int wait_cnt = 0;
    int fault_beat = 0;
    int beat_no = 0;
    bit finished = 1'b0;

    logic [63:0] exp_wr[$];
    logic [1:0]  exp_res[$];
    int          exp_lat[$];
    string       exp_tag[$];

    dws_store_seq u_dws_store_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cond_i(cond_i),
        .flags_i(flags_i), .up_i(up_i), .base_i(base_i), .offset_i(offset_i),
        .data_i(data_i), .big_endian_i(big_endian_i), .mem_valid_o(mem_valid_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i),
        .mem_fault_i(mem_fault_i), .done_o(done_o), .abort_o(abort_o),
        .misalign_o(misalign_o)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    function automatic bit ref_cond(input logic [3:0] c, input logic [3:0] f);
        bit n, z, cf, v, r;
        n = f[3]; z = f[2]; cf = f[1]; v = f[0];
        case (c[3:1])
            3'd0: r = z;
            3'd1: r = cf;
            3'd2: r = n;
            3'd3: r = v;
            3'd4: r = cf && !z;
            3'd5: r = (n == v);
            3'd6: r = !z && (n == v);
            default: r = 1'b1;
        endcase
        if (c == 4'hF) return 1'b0;
        return c[0] ? !r : r;
    endfunction

    // Memory model and monitor: sample away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_valid_o) begin
                if (wait_cnt < stall_n) begin
                    mem_ready_i = 1'b0;
                    mem_fault_i = 1'b0;
                    wait_cnt++;
                end else begin
                    wait_cnt = 0;
                    beat_no++;
                    mem_ready_i = 1'b1;
                    mem_fault_i = (beat_no == fault_beat);
                    if (exp_wr.size() == 0) begin
                        check(1'b0, "R5 unexpected beat", {mem_addr_o, mem_wdata_o}, 64'h0);
                    end else begin
                        logic [63:0] e;
                        e = exp_wr.pop_front();
                        check({mem_addr_o, mem_wdata_o} == e, "R2/R5 beat addr:data",
                              {mem_addr_o, mem_wdata_o}, e);
                    end
                end
            end else begin
                mem_ready_i = 1'b0;
                mem_fault_i = 1'b0;
            end
            if (done_o) begin
                if (exp_res.size() == 0) begin
                    check(1'b0, "R9 unexpected done", 64'h1, 64'h0);
                end else begin
                    logic [1:0] r;
                    int lat;
                    string tg;
                    r = exp_res.pop_front();
                    lat = exp_lat.pop_front();
                    tg = exp_tag.pop_front();
                    check({abort_o, misalign_o} == r, {tg, " result flags"},
                          {62'h0, abort_o, misalign_o}, {62'h0, r});
                    if (lat >= 0)
                        check(cyc == start_cyc + lat, {tg, " done latency"},
                              64'(cyc - start_cyc), 64'(lat));
                end
                done_cnt++;
            end
        end
    end

    task automatic do_store(input logic [3:0] c, input logic [3:0] f, input bit up,
                            input logic [31:0] base, input logic [7:0] off,
                            input logic [63:0] d, input bit be, input int stall,
                            input int fbeat, input bit chatter, input string tg);
        bit pass, mis;
        logic [31:0] ea, ea2, w0, w1;
        int prev;
        pass = ref_cond(c, f);
        mis  = (base[1:0] != 2'b00);
        ea   = up ? base + {22'h0, off, 2'b00} : base - {22'h0, off, 2'b00};
        ea2  = ea + 32'd4;
        w0   = be ? d[63:32] : d[31:0];
        w1   = be ? d[31:0]  : d[63:32];
        if (!pass) begin
            exp_res.push_back(2'b00); exp_lat.push_back(1); exp_tag.push_back({tg, " R4"});
        end else if (mis) begin
            exp_res.push_back(2'b01); exp_lat.push_back(1); exp_tag.push_back({tg, " R8"});
        end else begin
            exp_wr.push_back({ea, w0});
            if (fbeat != 1) exp_wr.push_back({ea2, w1});
            exp_res.push_back(fbeat != 0 ? 2'b10 : 2'b00);
            exp_lat.push_back(-1);
            exp_tag.push_back(fbeat != 0 ? {tg, " R7"} : {tg, " R9"});
        end
        prev = done_cnt;
        @(negedge clk);
        stall_n = stall; fault_beat = fbeat; beat_no = 0; wait_cnt = 0;
        cond_i = c; flags_i = f; up_i = up; base_i = base; offset_i = off;
        data_i = d; big_endian_i = be; start_i = 1'b1;
        start_cyc = cyc;
        @(negedge clk);
        if (chatter) begin
            // R1: stray start with different fields while the store runs
            cond_i = 4'hE; base_i = 32'h0000_0100; offset_i = 8'h7; data_i = ~d;
            big_endian_i = ~be; up_i = ~up;
            @(negedge clk);
        end
        start_i = 1'b0;
        while (done_cnt == prev) @(negedge clk);
        @(negedge clk);
        check(exp_wr.size() == 0 && exp_res.size() == 0, {tg, " R1 queues drained"},
              64'(exp_wr.size()), 64'h0);
        check(!mem_valid_o && !done_o, {tg, " R9 idle after done"},
              {62'h0, mem_valid_o, done_o}, 64'h0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        check(1'b0, "watchdog", 64'h0, 64'h1);
        wrap_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!mem_valid_o && !done_o && !abort_o && !misalign_o, "R9 reset state",
              {60'h0, mem_valid_o, done_o, abort_o, misalign_o}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        do_store(4'hE, 4'h0, 1'b1, 32'h0000_1000, 8'd3, 64'h1122_3344_5566_7788, 1'b1, 0, 0, 1'b0, "R2 R5 up big");
        do_store(4'hE, 4'h0, 1'b0, 32'h0000_1000, 8'd3, 64'hA1A2_A3A4_B1B2_B3B4, 1'b0, 2, 0, 1'b1, "R1 R6 down little stall");
        do_store(4'hE, 4'h0, 1'b1, 32'h0000_2000, 8'd0, 64'hDEAD_BEEF_CAFE_F00D, 1'b1, 1, 0, 1'b0, "R2 zero offset");
        do_store(4'hE, 4'h0, 1'b1, 32'hFFFF_FFF8, 8'd2, 64'h0102_0304_0506_0708, 1'b0, 0, 0, 1'b0, "R2 wrap up");
        do_store(4'hE, 4'h0, 1'b0, 32'h0000_0004, 8'd3, 64'h1111_2222_3333_4444, 1'b1, 0, 0, 1'b0, "R2 wrap down");
        do_store(4'hE, 4'h0, 1'b0, 32'h0001_0000, 8'd255, 64'h5555_6666_7777_8888, 1'b0, 0, 0, 1'b0, "R2 max offset");
        do_store(4'h0, 4'h0, 1'b1, 32'h0000_3000, 8'd1, 64'h9999_AAAA_BBBB_CCCC, 1'b1, 0, 0, 1'b0, "R3 R4 EQ fail");
        do_store(4'h0, 4'h4, 1'b1, 32'h0000_3000, 8'd1, 64'h9999_AAAA_BBBB_CCCC, 1'b1, 0, 0, 1'b0, "R3 EQ pass");
        do_store(4'hE, 4'h0, 1'b1, 32'h0000_4000, 8'd2, 64'h0BAD_0BAD_1234_5678, 1'b1, 1, 1, 1'b0, "R7 fault first");
        do_store(4'hE, 4'h0, 1'b1, 32'h0000_4000, 8'd2, 64'h0BAD_0BAD_1234_5678, 1'b0, 2, 2, 1'b1, "R7 fault second");
        do_store(4'hE, 4'h0, 1'b1, 32'h0000_5002, 8'd1, 64'h7777_7777_7777_7777, 1'b1, 0, 0, 1'b0, "R8 misaligned");
        do_store(4'hF, 4'h0, 1'b1, 32'h0000_5001, 8'd1, 64'h7777_7777_7777_7777, 1'b1, 0, 0, 1'b0, "R8 R4 misaligned never");
        for (int c = 0; c < 16; c++) begin
            do_store(4'(c), 4'b1010, 1'b1, 32'h0000_6000, 8'(c), {32'(c), 32'hFACE_0000 | 32'(c)}, 1'b1, 0, 0, 1'b0, "R3 sweep A");
            do_store(4'(c), 4'b0110, 1'b0, 32'h0000_7000, 8'(c), {32'hC0DE_0000 | 32'(c), 32'(c)}, 1'b0, 0, 0, 1'b0, "R3 sweep B");
        end
        repeat (3) @(negedge clk);
        wrap_up();
    end
endmodule